// File: doc/BRIEF.md
# Sticky Fault Supervisor with Alert

This block supervises temperature faults for a switching regulator controller. It watches two digitised inputs. The first is a thermistor voltage code, which is compared against a programmable limit. The second is a die temperature code, which is checked against a trip threshold and a lower release threshold. Each fault condition passes through a synchroniser and a persistence filter before the block acts on it.

An accepted fault sets a sticky bit in a status register. While any status bit is set, an active-low alert output is held low. A per-bit protection mask decides whether the external fault only raises a flag or also stops PWM switching. A per-bit response setting selects the action taken when switching is stopped:

- Hiccup: switching resumes through a soft-start request once the condition clears.
- Latch-off: switching stays off until an enable/power-on recycle.

The die fault always stops switching and always restarts through soft-start once the die has cooled below its release point.

Software reaches the block through a small register write port. The status register is write-one-to-clear. A clear-all strobe and the enable/power-on reset also clear the status bits.

Top module: `fault_supervisor`

## Requirements
- R1: The external fault condition is `ntc_code < limit` (strictly below), and it counts only while `ss_begun` is 1. While `ss_begun` is 0 the code is ignored. The limit resets to code 128, which is 300 mV on a 2400 mV, 10-bit scale.
- R2: An accepted external fault sets status bit 3 (`fault_flags[3]`) and drives `alert_n` low, whatever the mask setting.
- R3: Mask bit 3 resets to 1. While it is 1, an external fault only flags and alerts, and `pwm_en` stays 1.
- R4: With mask bit 3 at 0 and response bit 3 at 0 (hiccup), an external fault drives `pwm_en` to 0. Once the condition clears, `pwm_en` returns to 1 and `ss_restart` gives exactly one single-cycle pulse.
- R5: With mask bit 3 at 0 and response bit 3 at 1 (latch-off), `pwm_en` stays 0 after the condition clears. Only a low level on `en_por_n` brings it back to 1.
- R6: The block never clears a status bit by itself. Writing 1 to a bit at address 0 clears that bit, and writing 0 leaves it unchanged. A `clear_all` pulse clears every bit. `en_por_n` low clears every bit.
- R7: If a fault is present in the same cycle as a clear request, the fault wins and its status bit stays 1.
- R8: `alert_n` is 1 exactly when all status bits are 0.
- R9: The die code reads as degrees C plus 64. A code of 224 (160 C) or above trips the die fault. The trip sets status bit 6 and drives `pwm_en` to 0, whatever the mask. `pwm_en` comes back, with one `ss_restart` pulse, only when the code falls below 209 (145 C). Codes in between keep the fault state unchanged.
- R10: A fault condition must hold for 4 consecutive clock cycles before it is accepted. A 3-cycle condition leaves no trace.
- R11: The register map is: address 0 status (write-one-to-clear), address 1 mask, address 2 response, address 3 thermistor limit. The mask and response registers take `wr_data[7:0]`; the limit takes `wr_data[9:0]`. The response register resets to 0 (hiccup).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| en_por_n | input | 1 | Active-low enable/power-on reset; recycling it clears the status bits and any latch-off |
| ntc_code | input | 10 | Thermistor voltage code |
| die_code | input | 8 | Die temperature code (degrees C + 64) |
| ss_begun | input | 1 | High once soft-start has started; enables external fault detection |
| clear_all | input | 1 | One-cycle strobe that clears all status bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 10 | Register write data |
| alert_n | output | 1 | Active-low alert; low while any status bit is set |
| pwm_en | output | 1 | PWM switching enable |
| ss_restart | output | 1 | One-cycle soft-start restart request |
| fault_flags | output | 8 | Status register contents |

## Verification
A table of thermistor code, limit and soft-start settings drives the comparator:

- Codes one below the limit set the flag.
- Codes equal to the limit do not, which separates `<` from `<=`.
- Limits at 0 and full scale exercise the range ends.
- A low code with soft-start not begun shows that the gate works.

Directed sequences then run the main paths:

- Persistence: pulses of 3 and 4 cycles separate the accept length from an off-by-one.
- Clear-versus-set collision: a clear requested while the fault is still present.
- Write-one-to-clear selectivity: a write naming another bit, then one naming bit 3.
- Responses: hiccup against latch-off, each observed after the fault clears.
- Die band: codes just below the trip, at the trip, inside the band and just below the release point show the hysteresis.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

  typedef enum logic [1:0] {
    PS_RUN   = 2'd0,
    PS_HOLD  = 2'd1,
    PS_LATCH = 2'd2
  } prot_state_t;

  localparam int unsigned REG_W      = 8;
  localparam int unsigned BIT_EXT_OT = 3;
  localparam int unsigned BIT_DIE_OT = 6;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_RESP   = 2'd2;
  localparam logic [1:0] ADDR_LIMIT  = 2'd3;

  // millivolts -> ADC code on a full-scale range of full_mv
  function automatic int unsigned mv_to_code(input int unsigned mv,
                                             input int unsigned full_mv,
                                             input int unsigned bits);
    return (mv * (32'd1 << bits)) / full_mv;
  endfunction

  // degrees C -> die temperature code
  function automatic int unsigned degc_to_code(input int unsigned degc,
                                               input int unsigned offset);
    return degc + offset;
  endfunction

endpackage

// File: rtl/fsup_filter.sv
module fsup_filter #(
  parameter int unsigned PERSIST = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level
);
  localparam int unsigned CNT_W = $clog2(PERSIST) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERSIST - 1);

  logic             s1, s2;
  logic [CNT_W-1:0] cnt;
  logic             differs;

  assign differs = (s2 != level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (differs) begin
      if (cnt == LAST) begin
        level <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  AST_PERSIST_MET: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(level) |-> ($past(cnt) == LAST)); // R10

endmodule

// File: rtl/fsup_protect.sv
module fsup_protect
  import fsup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic arm,
  input  logic latch_sel,
  output logic inhibit
);
  prot_state_t state, state_n;

  always_comb begin
    state_n = state;
    unique case (state)
      PS_RUN:   if (cond && arm) state_n = latch_sel ? PS_LATCH : PS_HOLD;
      PS_HOLD:  if (!cond)       state_n = PS_RUN;
      PS_LATCH: state_n = PS_LATCH;
      default:  state_n = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_RUN;
    else        state <= state_n;
  end

  assign inhibit = (state != PS_RUN);

  AST_ARM_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> $past(arm && cond)); // R3
  AST_HOLD_WHILE_COND: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && cond) |=> inhibit); // R4
  AST_LATCH_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_LATCH) |=> inhibit); // R5

endmodule

// File: rtl/fsup_regs.sv
module fsup_regs
  import fsup_pkg::*;
#(
  parameter int unsigned NTC_W     = 10,
  parameter int unsigned DATA_W    = 10,
  parameter int unsigned LIMIT_RST = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear_all,
  input  logic [REG_W-1:0]  set_vec,
  output logic [REG_W-1:0]  status,
  output logic [REG_W-1:0]  mask,
  output logic [REG_W-1:0]  resp,
  output logic [NTC_W-1:0]  limit
);
  logic [REG_W-1:0] clr_vec;

  always_comb begin
    clr_vec = {REG_W{clear_all}};
    if (wr_en && wr_addr == ADDR_STATUS) clr_vec = clr_vec | wr_data[REG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
      resp   <= '0;
      limit  <= NTC_W'(LIMIT_RST);
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (wr_en && wr_addr == ADDR_MASK)  mask  <= wr_data[REG_W-1:0];
      if (wr_en && wr_addr == ADDR_RESP)  resp  <= wr_data[REG_W-1:0];
      if (wr_en && wr_addr == ADDR_LIMIT) limit <= wr_data[NTC_W-1:0];
    end
  end

  AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status & ~$past(clr_vec)) == '0)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_vec) & ~status) == '0)); // R7

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned NTC_W       = 10,
  parameter int unsigned DIE_W       = 8,
  parameter int unsigned FULL_MV     = 2400,
  parameter int unsigned NTC_TRIP_MV = 300,
  parameter int unsigned DIE_OFFSET  = 64,
  parameter int unsigned DIE_TRIP_C  = 160,
  parameter int unsigned DIE_HYST_C  = 15,
  parameter int unsigned PERSIST     = 4,
  parameter int unsigned DATA_W      = (NTC_W > REG_W) ? NTC_W : REG_W
) (
  input  logic              clk,
  input  logic              en_por_n,
  input  logic [NTC_W-1:0]  ntc_code,
  input  logic [DIE_W-1:0]  die_code,
  input  logic              ss_begun,
  input  logic              clear_all,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              alert_n,
  output logic              pwm_en,
  output logic              ss_restart,
  output logic [REG_W-1:0]  fault_flags
);
  localparam int unsigned LIMIT_RST = mv_to_code(NTC_TRIP_MV, FULL_MV, NTC_W);
  localparam logic [DIE_W-1:0] DIE_TRIP_CODE =
    DIE_W'(degc_to_code(DIE_TRIP_C, DIE_OFFSET));
  localparam logic [DIE_W-1:0] DIE_REL_CODE =
    DIE_W'(degc_to_code(DIE_TRIP_C - DIE_HYST_C, DIE_OFFSET));
  localparam int unsigned N_RAW = 3;
  localparam int unsigned IX_EXT = 0, IX_HOT = 1, IX_COOL = 2;

  logic [REG_W-1:0] status, mask, resp, set_vec;
  logic [NTC_W-1:0] limit;
  logic [N_RAW-1:0] raw_cond, filt_cond;
  logic             ext_f, die_hot_f, die_cool_f;
  logic             die_state;
  logic             ext_inhibit, die_inhibit;
  logic             pwm_q;

  // raw comparisons before synchronisation
  assign raw_cond[IX_EXT]  = ss_begun && (ntc_code < limit);
  assign raw_cond[IX_HOT]  = (die_code >= DIE_TRIP_CODE);
  assign raw_cond[IX_COOL] = (die_code <  DIE_REL_CODE);

  for (genvar g = 0; g < N_RAW; g++) begin : g_filt
    fsup_filter #(.PERSIST(PERSIST)) u_filt (
      .clk   (clk),
      .rst_n (en_por_n),
      .raw   (raw_cond[g]),
      .level (filt_cond[g])
    );
  end

  assign ext_f      = filt_cond[IX_EXT];
  assign die_hot_f  = filt_cond[IX_HOT];
  assign die_cool_f = filt_cond[IX_COOL];

  // die hysteresis state
  always_ff @(posedge clk or negedge en_por_n) begin
    if (!en_por_n)       die_state <= 1'b0;
    else if (die_hot_f)  die_state <= 1'b1;
    else if (die_cool_f) die_state <= 1'b0;
  end

  always_comb begin
    set_vec             = '0;
    set_vec[BIT_EXT_OT] = ext_f;
    set_vec[BIT_DIE_OT] = die_state;
  end

  fsup_regs #(
    .NTC_W     (NTC_W),
    .DATA_W    (DATA_W),
    .LIMIT_RST (LIMIT_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (en_por_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .clear_all (clear_all),
    .set_vec   (set_vec),
    .status    (status),
    .mask      (mask),
    .resp      (resp),
    .limit     (limit)
  );

  fsup_protect u_prot_ext (
    .clk       (clk),
    .rst_n     (en_por_n),
    .cond      (ext_f),
    .arm       (!mask[BIT_EXT_OT]),
    .latch_sel (resp[BIT_EXT_OT]),
    .inhibit   (ext_inhibit)
  );

  fsup_protect u_prot_die (
    .clk       (clk),
    .rst_n     (en_por_n),
    .cond      (die_state),
    .arm       (1'b1),
    .latch_sel (1'b0),
    .inhibit   (die_inhibit)
  );

  always_ff @(posedge clk or negedge en_por_n) begin
    if (!en_por_n) pwm_q <= 1'b1;
    else           pwm_q <= pwm_en;
  end

  assign pwm_en      = !(ext_inhibit || die_inhibit);
  assign ss_restart  = pwm_en && !pwm_q;
  assign alert_n     = (status == '0);
  assign fault_flags = status;

  AST_EXT_FLAGGED: assert property (@(posedge clk) disable iff (!en_por_n)
    $rose(ext_f) |=> fault_flags[BIT_EXT_OT]); // R2
  AST_ALERT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!en_por_n)
    $rose(alert_n) |-> $past(clear_all || (wr_en && wr_addr == ADDR_STATUS))); // R6
  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!en_por_n)
    ss_restart |=> !ss_restart); // R4
  AST_DIE_RELEASE: assert property (@(posedge clk) disable iff (!en_por_n)
    $fell(die_state) |-> $past(die_cool_f)); // R9
  AST_DIE_STOPS_PWM: assert property (@(posedge clk) disable iff (!en_por_n)
    die_state |=> !pwm_en); // R9

endmodule

// File: tb/sim_fault_supervisor.sv
module sim_fault_supervisor;
  logic       clk = 1'b0;
  logic       en_por_n = 1'b0;
  logic [9:0] ntc_code = 10'd1000;
  logic [7:0] die_code = 8'd100;
  logic       ss_begun = 1'b0;
  logic       clear_all = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = '0;
  logic       alert_n, pwm_en, ss_restart;
  logic [7:0] fault_flags;

  int checks = 0;
  int failures = 0;
  int restarts = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fault_supervisor u0 (
    .clk(clk), .en_por_n(en_por_n), .ntc_code(ntc_code), .die_code(die_code),
    .ss_begun(ss_begun), .clear_all(clear_all), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .alert_n(alert_n), .pwm_en(pwm_en), .ss_restart(ss_restart),
    .fault_flags(fault_flags)
  );

  always @(negedge clk) if (en_por_n && ss_restart) restarts++;

  // {ss_begun, limit, code, expected flag}
  localparam logic [21:0] VECS [8] = '{
    {1'b1, 10'd128,  10'd127,  1'b1},
    {1'b1, 10'd128,  10'd128,  1'b0},
    {1'b1, 10'd128,  10'd500,  1'b0},
    {1'b0, 10'd128,  10'd0,    1'b0},
    {1'b1, 10'd300,  10'd299,  1'b1},
    {1'b1, 10'd300,  10'd300,  1'b0},
    {1'b1, 10'd0,    10'd0,    1'b0},
    {1'b1, 10'd1023, 10'd1022, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_all = 1'b1;
    @(negedge clk);
    clear_all = 1'b0;
  endtask

  task automatic ntc_low_for(input int n);
    @(negedge clk);
    ntc_code = 10'd0;
    repeat (n) @(negedge clk);
    ntc_code = 10'd1000;
  endtask

  task automatic por_cycle();
    @(negedge clk);
    en_por_n = 1'b0;
    wait_cyc(2);
    en_por_n = 1'b1;
    wait_cyc(2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0;
    wait_cyc(3);
    en_por_n = 1'b1;
    wait_cyc(2);
    // reset state
    check("R8 reset alert_n", alert_n, 1);
    check("R6 reset flags", fault_flags, 0);
    check("R3 reset pwm_en", pwm_en, 1);
    check("R4 reset ss_restart", ss_restart, 0);

    // R1 R2 R3 R11: comparator table walk (mask default keeps PWM running)
    for (int i = 0; i < 8; i++) begin
      ss_begun = 1'b0; ntc_code = 10'd1023;
      wait_cyc(8);
      pulse_clear();
      reg_write(2'd3, VECS[i][20:11]);
      @(negedge clk);
      ss_begun = VECS[i][21];
      ntc_code = VECS[i][10:1];
      wait_cyc(10);
      check("R1 ext flag", fault_flags[3], VECS[i][0]);
      check("R2 alert_n", alert_n, !VECS[i][0]);
      check("R3 masked pwm_en", pwm_en, 1);
      ntc_code = 10'd1023;
      wait_cyc(10);
      if (VECS[i][0]) check("R6 flag sticks after release", fault_flags[3], 1);
    end

    // restore limit 128, soft-start begun
    ss_begun = 1'b1; ntc_code = 10'd1000;
    reg_write(2'd3, 10'd128);
    pulse_clear();
    wait_cyc(2);
    check("R8 alert released", alert_n, 1);

    // R10 persistence
    ntc_low_for(3);
    wait_cyc(10);
    check("R10 3-cycle glitch rejected", fault_flags[3], 0);
    ntc_low_for(4);
    wait_cyc(10);
    check("R10 4-cycle accepted", fault_flags[3], 1);

    // R6 write-one-to-clear selectivity
    reg_write(2'd0, 10'h040);
    wait_cyc(1);
    check("R6 other bit W1C keeps bit3", fault_flags[3], 1);
    reg_write(2'd0, 10'h008);
    wait_cyc(1);
    check("R6 W1C clears bit3", fault_flags[3], 0);
    check("R8 alert after W1C", alert_n, 1);

    // R7 set wins over clear
    @(negedge clk); ntc_code = 10'd10;
    wait_cyc(10);
    pulse_clear();
    wait_cyc(1);
    check("R7 clear_all while fault", fault_flags[3], 1);
    reg_write(2'd0, 10'h008);
    wait_cyc(1);
    check("R7 W1C while fault", fault_flags[3], 1);
    ntc_code = 10'd1000;
    wait_cyc(10);
    pulse_clear();
    wait_cyc(1);
    check("R6 clear after release", fault_flags, 0);

    // R4 hiccup
    reg_write(2'd1, 10'h0F7);
    r0 = restarts;
    @(negedge clk); ntc_code = 10'd50;
    wait_cyc(10);
    check("R4 hiccup pwm off", pwm_en, 0);
    ntc_code = 10'd1000;
    wait_cyc(12);
    check("R4 hiccup pwm back", pwm_en, 1);
    check("R4 one restart pulse", restarts - r0, 1);
    check("R6 flag after hiccup", fault_flags[3], 1);
    check("R8 alert held after hiccup", alert_n, 0);

    // R5 latch-off
    reg_write(2'd2, 10'h008);
    pulse_clear();
    r0 = restarts;
    @(negedge clk); ntc_code = 10'd50;
    wait_cyc(10);
    check("R5 latch pwm off", pwm_en, 0);
    ntc_code = 10'd1000;
    wait_cyc(20);
    check("R5 latch holds", pwm_en, 0);
    check("R5 no restart", restarts - r0, 0);
    por_cycle();
    check("R5 por re-enables", pwm_en, 1);
    check("R6 por clears flags", fault_flags, 0);

    // R9 die hysteresis (mask at reset value, all ones)
    ss_begun = 1'b1;
    r0 = restarts;
    @(negedge clk); die_code = 8'd223;
    wait_cyc(10);
    check("R9 below trip", pwm_en, 1);
    die_code = 8'd224;
    wait_cyc(10);
    check("R9 trip pwm off", pwm_en, 0);
    check("R9 die flag", fault_flags[6], 1);
    check("R9 alert", alert_n, 0);
    die_code = 8'd215;
    wait_cyc(10);
    check("R9 in band stays off", pwm_en, 0);
    die_code = 8'd209;
    wait_cyc(10);
    check("R9 at release stays off", pwm_en, 0);
    die_code = 8'd208;
    wait_cyc(12);
    check("R9 released pwm on", pwm_en, 1);
    check("R9 restart pulse", restarts - r0, 1);
    check("R9 flag sticky", fault_flags[6], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule